// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a clocked system and an external asynchronous static RAM with a 19-bit address and an 8-bit data bus. It accepts one single-byte read or write at a time over a valid/ready request port. It turns each request into a sequence of chip-select, output-enable and write-enable levels whose phase lengths are whole clock cycles. Those cycle counts are derived at elaboration time from the clock period parameter and a speed-bin parameter, which picks the 70, 85 or 100 ns timing set. Each nanosecond limit is rounded up to whole cycles.

A write is the overlap of chip select and write enable. The controller lowers both on the same edge, drives the data bus only inside that overlap, and releases the bus on the edge where both rise. A read holds chip select and output enable low for the access time plus one cycle of margin, then samples the data bus as the strobes rise. It returns the byte as a one-cycle `rsp_valid` pulse, which has no back-pressure: the consumer must take it in that cycle. After a read the controller waits out the output high-Z time before it accepts further work, so a following write cannot drive into a bus that is still being released.

Back-pressure rules on the request port:
- A request is taken on a rising edge where `req_valid` and `req_ready` are both high.
- While `req_valid` is high and `req_ready` is low, the requester holds address, write flag and data steady.
- `req_ready` stays low from the accept edge until the operation's full occupancy has passed.
- A plain `retain_i` input parks the RAM deselected for data retention. When it is released, a recovery delay passes before any access starts.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on an edge with `req_valid` and `req_ready` high, and its strobes begin on that same edge. `req_ready` is never high while `mem_cs_n` is 0.
- R3: A read holds `mem_cs_n` and `mem_oe_n` at 0 and `mem_we_n` at 1 for RD cycles, with the address unchanged. RD = max(ceil(max(tAA,tCO,tOE)/T)+1, ceil(tRC/T)), which is 8 at T=10 ns in the 70 ns bin.
- R4: `rsp_valid` is 1 for exactly one cycle, starting at the edge where the read strobes rise. It carries the byte present on `mem_dq_in` at that edge. It never pulses for a write.
- R5: A write lowers `mem_cs_n` and `mem_we_n` on the same edge and keeps both low for WIN cycles, with `mem_oe_n` at 1 throughout. WIN = max(ceil(tWP/T), ceil(tCW/T), ceil(tAW/T), ceil(tDW/T), 1), which is 6 in the 70 ns bin at 10 ns.
- R6: `mem_dq_oe` is 1 only while `mem_cs_n` and `mem_we_n` are both 0, and it is 1 for that whole window. During the window `mem_dq_out` holds the requested byte unchanged. The bus is released on the edge where write enable rises.
- R7: A write occupies max(WIN, ceil(tWC/T)) cycles, which is 7 at defaults. `req_ready` is first seen high again at the 8th falling edge after the accept edge.
- R8: After a read, at least ceil(tHZ/T) cycles separate the rise of `mem_oe_n` from the next rise of `mem_dq_oe`. A read occupies RD+ceil(tHZ/T) cycles, which is 11 at defaults.
- R9: While `retain_i` is 1 and the controller is idle, `mem_cs_n` stays 1, `req_ready` stays 0 and a waiting request is not started. After `retain_i` falls, `req_ready` stays 0 for ceil(RECOVER_NS/T) further cycles, and then the held request runs.
- R10: `SPEED_NS` of 85 or 100 selects that bin's own limits. At 100 ns and T=10 ns, a read lasts 11 cycles, a write window lasts 8 cycles, a write occupies 10 cycles and a read occupies 14 cycles.
- R11: All 19 address bits reach `mem_addr`. Bytes written at address 0 and at address 0x7FFFF read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Byte read |
| retain_i | input | 1 | Hold the RAM deselected for data retention |
| mem_addr | output | 19 | RAM address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_in | input | 8 | Data arriving from the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The bench stimulus covers several cases:
- Writes and reads of 0x00, 0xFF and 0xA5 at the lowest, highest and a middle address. Read-back tells address and data routing apart from stuck or swapped bits.
- A RAM model that presents a wrong byte until the access time has elapsed. A sample point placed too early therefore shows up as bad data rather than passing silently.
- A read followed at once by a write. This separates a correct high-Z gap from one that is missing.
- A request held waiting through a retention interval. This shows whether the controller holds it off and then counts the full recovery.
- A second instance built for the 100 ns bin. It shows that the phase lengths follow the bin parameter rather than fixed constants.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_TURN, ST_WRITE, ST_WTAIL, ST_SLEEP, ST_WAKE
  } seq_state_e;

  typedef enum int unsigned {
    TK_RC, TK_AA, TK_CO, TK_OE, TK_HZ, TK_WC, TK_CW, TK_AW, TK_WP, TK_DW
  } time_kind_e;

  // Limit in ns for one speed bin; unknown bins fall back to the fastest set.
  function automatic int unsigned bin_time(input int unsigned bin_ns, input time_kind_e k);
    int unsigned v;
    v = 0;
    case (bin_ns)
      100: case (k)
        TK_RC, TK_AA, TK_CO, TK_WC: v = 100;
        TK_OE: v = 50;
        TK_HZ: v = 30;
        TK_CW, TK_AW: v = 80;
        TK_WP: v = 70;
        TK_DW: v = 40;
        default: v = 0;
      endcase
      85: case (k)
        TK_RC, TK_AA, TK_CO, TK_WC: v = 85;
        TK_OE: v = 40;
        TK_HZ: v = 25;
        TK_CW, TK_AW: v = 70;
        TK_WP: v = 55;
        TK_DW: v = 35;
        default: v = 0;
      endcase
      default: case (k)
        TK_RC, TK_AA, TK_CO, TK_WC: v = 70;
        TK_OE: v = 35;
        TK_HZ: v = 25;
        TK_CW, TK_AW: v = 60;
        TK_WP: v = 55;
        TK_DW: v = 30;
        default: v = 0;
      endcase
    endcase
    return v;
  endfunction

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    if (ns == 0) return 0;
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign last = (cnt == CNT_W'(1));

  // A phase is never opened with zero length (R2 occupancy accounting).
  assert_phase_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned RD_LEN    = 8,
  parameter int unsigned TURN_LEN  = 3,
  parameter int unsigned WIN_LEN   = 6,
  parameter int unsigned WTAIL_LEN = 1,
  parameter int unsigned WAKE_LEN  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             retain,
  input  logic             phase_last,
  output logic             req_ready,
  output logic             take_req,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             capture,
  output logic             cs_n_d,
  output logic             oe_n_d,
  output logic             we_n_d,
  output logic             dq_oe_d,
  output seq_state_e       state_o
);

  seq_state_e state, nxt;

  assign req_ready = (state == ST_IDLE) && !retain;
  assign take_req  = req_ready && req_valid;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    capture  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (retain) begin
          nxt = ST_SLEEP;
        end else if (req_valid) begin
          load = 1'b1;
          if (req_write) begin
            nxt      = ST_WRITE;
            load_val = CNT_W'(WIN_LEN);
          end else begin
            nxt      = ST_READ;
            load_val = CNT_W'(RD_LEN);
          end
        end
      end
      ST_READ: begin
        if (phase_last) begin
          capture = 1'b1;
          if (TURN_LEN != 0) begin
            nxt      = ST_TURN;
            load     = 1'b1;
            load_val = CNT_W'(TURN_LEN);
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      ST_TURN: if (phase_last) nxt = ST_IDLE;
      ST_WRITE: begin
        if (phase_last) begin
          if (WTAIL_LEN != 0) begin
            nxt      = ST_WTAIL;
            load     = 1'b1;
            load_val = CNT_W'(WTAIL_LEN);
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      ST_WTAIL: if (phase_last) nxt = ST_IDLE;
      ST_SLEEP: begin
        if (!retain) begin
          if (WAKE_LEN != 0) begin
            nxt      = ST_WAKE;
            load     = 1'b1;
            load_val = CNT_W'(WAKE_LEN);
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      ST_WAKE: begin
        if (retain) nxt = ST_SLEEP;
        else if (phase_last) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // Pin levels for the coming cycle follow the state being entered.
  assign cs_n_d  = !((nxt == ST_READ) || (nxt == ST_WRITE));
  assign oe_n_d  = (nxt != ST_READ);
  assign we_n_d  = (nxt != ST_WRITE);
  assign dq_oe_d = (nxt == ST_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign state_o = state;

  // The capture strobe only closes a read phase (R4).
  assert_capture_closes_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (state != ST_READ));

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic              cs_n_d,
  input  logic              oe_n_d,
  input  logic              we_n_d,
  input  logic              dq_oe_d,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      mem_cs_n  <= cs_n_d;
      mem_oe_n  <= oe_n_d;
      mem_we_n  <= we_n_d;
      mem_dq_oe <= dq_oe_d;
      rsp_valid <= capture;
      if (take_req) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end

  assert_bus_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_cs_n && !mem_we_n));

  assert_bus_data_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  assert_oe_off_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  assert_rsp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned SPEED_NS   = 70,
  parameter int unsigned RECOVER_NS = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              retain_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int unsigned ACC_NS    = max2(max2(bin_time(SPEED_NS, TK_AA), bin_time(SPEED_NS, TK_CO)),
                                           bin_time(SPEED_NS, TK_OE));
  localparam int unsigned RD_LEN    = max2(ns2cyc(ACC_NS, CLK_NS) + 1,
                                           ns2cyc(bin_time(SPEED_NS, TK_RC), CLK_NS));
  localparam int unsigned TURN_LEN  = ns2cyc(bin_time(SPEED_NS, TK_HZ), CLK_NS);
  localparam int unsigned WIN_LEN   = max2(max2(ns2cyc(bin_time(SPEED_NS, TK_WP), CLK_NS),
                                                ns2cyc(bin_time(SPEED_NS, TK_CW), CLK_NS)),
                                           max2(ns2cyc(bin_time(SPEED_NS, TK_AW), CLK_NS),
                                                max2(ns2cyc(bin_time(SPEED_NS, TK_DW), CLK_NS), 1)));
  localparam int unsigned WC_LEN    = ns2cyc(bin_time(SPEED_NS, TK_WC), CLK_NS);
  localparam int unsigned WTAIL_LEN = (WC_LEN > WIN_LEN) ? (WC_LEN - WIN_LEN) : 0;
  localparam int unsigned WAKE_LEN  = ns2cyc(RECOVER_NS, CLK_NS);
  localparam int unsigned LONGEST   = max2(max2(RD_LEN, WIN_LEN),
                                           max2(WAKE_LEN, max2(TURN_LEN, WTAIL_LEN)));
  localparam int unsigned CNT_W     = bits_for(LONGEST);

  logic             phase_last, take_req, load, capture;
  logic [CNT_W-1:0] load_val;
  logic             cs_n_d, oe_n_d, we_n_d, dq_oe_d;
  seq_state_e       seq_state;

  sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .last     (phase_last)
  );

  sram_seq_fsm #(
    .CNT_W     (CNT_W),
    .RD_LEN    (RD_LEN),
    .TURN_LEN  (TURN_LEN),
    .WIN_LEN   (WIN_LEN),
    .WTAIL_LEN (WTAIL_LEN),
    .WAKE_LEN  (WAKE_LEN)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .retain     (retain_i),
    .phase_last (phase_last),
    .req_ready  (req_ready),
    .take_req   (take_req),
    .load       (load),
    .load_val   (load_val),
    .capture    (capture),
    .cs_n_d     (cs_n_d),
    .oe_n_d     (oe_n_d),
    .we_n_d     (we_n_d),
    .dq_oe_d    (dq_oe_d),
    .state_o    (seq_state)
  );

  sram_pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pins_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_req   (take_req),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture    (capture),
    .cs_n_d     (cs_n_d),
    .oe_n_d     (oe_n_d),
    .we_n_d     (we_n_d),
    .dq_oe_d    (dq_oe_d),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  assert_busy_hides_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  assert_accept_selects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !mem_cs_n);

  assert_window_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $fell(mem_cs_n));

  assert_retain_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_state == ST_SLEEP) || (seq_state == ST_WAKE)) |-> (mem_cs_n && !req_ready));

endmodule

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RECOV_NS   = 300;
  localparam int T_AA       = 70;
  localparam int EXP_RD     = 8;
  localparam int EXP_TURN   = 3;
  localparam int EXP_WIN    = 6;
  localparam int EXP_WTAIL  = 1;
  localparam int EXP_WAKE   = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, retain = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = '0;

  logic        b_valid = 1'b0, b_write = 1'b0;
  logic        b_ready, b_rsp_valid, b_cs_n, b_oe_n, b_we_n, b_dq_oe;
  logic [7:0]  b_rdata, b_dq_out;
  logic [18:0] b_addr;

  int checks = 0;
  int fails  = 0;

  sram_strobe_ctrl #(.CLK_NS(CLK_PERIOD), .SPEED_NS(70), .RECOVER_NS(RECOV_NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .retain_i(retain),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

  sram_strobe_ctrl #(.CLK_NS(CLK_PERIOD), .SPEED_NS(100), .RECOVER_NS(RECOV_NS)) dut100_i (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
    .req_write(b_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(b_rsp_valid), .rsp_rdata(b_rdata), .retain_i(1'b0),
    .mem_addr(b_addr), .mem_cs_n(b_cs_n), .mem_oe_n(b_oe_n), .mem_we_n(b_we_n),
    .mem_dq_out(b_dq_out), .mem_dq_in(8'h00), .mem_dq_oe(b_dq_oe));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // RAM model and timing monitor, sampled on falling edges.
  logic [7:0]  ram [int unsigned];
  int          rd_age = 0, rd_len = 0, win_len = 0, win_drv = 0, since_oe = 1000;
  logic [18:0] w_addr = '0;
  logic [7:0]  w_data = '0, prev_dq = '0;
  logic        prev_oe_low = 1'b0, prev_drv = 1'b0;

  always @(negedge clk) begin
    logic [7:0] b;
    if (rst_n) begin
      // read side
      if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
        rd_age++;
        rd_len++;
      end else begin
        if (rd_len != 0) chk(rd_len == EXP_RD, "R3", "read strobe cycles", rd_len, EXP_RD);
        rd_age = 0;
        rd_len = 0;
      end
      b = ram.exists(mem_addr) ? ram[mem_addr] : 8'h00;
      mem_dq_in = (rd_age * CLK_PERIOD >= T_AA) ? b : ~b;
      // write side
      if (!mem_cs_n && !mem_we_n) begin
        win_len++;
        if (mem_dq_oe) win_drv++;
        if (mem_dq_oe && prev_drv && mem_dq_out != prev_dq)
          chk(1'b0, "R6", "bus data changed in window", mem_dq_out, prev_dq);
        w_addr = mem_addr;
        w_data = mem_dq_out;
      end else if (win_len != 0) begin
        ram[w_addr] = w_data;
        chk(win_len == EXP_WIN, "R5", "write window cycles", win_len, EXP_WIN);
        chk(win_drv == win_len, "R6", "bus driven cycles in window", win_drv, win_len);
        win_len = 0;
        win_drv = 0;
      end
      // turnaround
      if (mem_oe_n && prev_oe_low) since_oe = 0;
      else if (since_oe < 1000) since_oe++;
      if (mem_dq_oe && !prev_drv)
        chk(since_oe >= EXP_TURN, "R8", "cycles from OE release to bus drive", since_oe, EXP_TURN);
      prev_oe_low = !mem_oe_n;
      prev_drv    = mem_dq_oe;
      prev_dq     = mem_dq_out;
    end
  end

  task automatic t_reset();
    chk(mem_cs_n && mem_oe_n && mem_we_n, "R1", "strobes high after reset",
        {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(!mem_dq_oe, "R1", "bus released after reset", mem_dq_oe, 0);
    chk(req_ready && !rsp_valid, "R1", "ready high, no response", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    int n, rsp_seen;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_cs_n && !mem_we_n, "R2", "strobes low after accept edge", {mem_cs_n, mem_we_n}, 0);
    n = 1; rsp_seen = 0;
    while (!req_ready && n < 200) begin
      if (rsp_valid) rsp_seen++;
      @(negedge clk); n++;
    end
    chk(n == EXP_WIN + EXP_WTAIL + 1, "R7", "write busy span", n, EXP_WIN + EXP_WTAIL + 1);
    chk(rsp_seen == 0, "R4", "response pulses during write", rsp_seen, 0);
  endtask

  task automatic do_read(input logic [18:0] a, input logic [7:0] exp);
    int n, at, pulses;
    logic [7:0] got;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1; at = 0; pulses = 0; got = '0;
    while (!req_ready && n < 200) begin
      if (rsp_valid) begin pulses++; at = n; got = rsp_rdata; end
      @(negedge clk); n++;
    end
    chk(pulses == 1, "R4", "response pulse count", pulses, 1);
    chk(at == EXP_RD + 1, "R4", "response cycle", at, EXP_RD + 1);
    chk(got == exp, "R11", "read-back byte", got, exp);
    chk(n == EXP_RD + EXP_TURN + 1, "R8", "read busy span", n, EXP_RD + EXP_TURN + 1);
  endtask

  task automatic t_retention();
    int bad, n;
    @(negedge clk);
    retain = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h12345; req_wdata = 8'h3C;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!mem_cs_n || req_ready) bad++;
    end
    chk(bad == 0, "R9", "cycles selected or ready during retention", bad, 0);
    retain = 1'b0;
    n = 0;
    while (!req_ready && n < 200) begin @(negedge clk); n++; end
    chk(n == EXP_WAKE + 1, "R9", "recovery cycles before ready", n, EXP_WAKE + 1);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    do_read(19'h12345, 8'h3C);
  endtask

  task automatic t_bin100();
    int n, len;
    @(negedge clk);
    b_valid = 1'b1; b_write = 1'b1; req_addr = 19'h00042; req_wdata = 8'h77;
    @(negedge clk);
    b_valid = 1'b0;
    n = 1; len = 0;
    while (!b_ready && n < 200) begin
      if (!b_cs_n && !b_we_n) len++;
      @(negedge clk); n++;
    end
    chk(len == 8, "R10", "100 ns bin write window", len, 8);
    chk(n == 11, "R10", "100 ns bin write busy span", n, 11);
    @(negedge clk);
    b_valid = 1'b1; b_write = 1'b0;
    @(negedge clk);
    b_valid = 1'b0;
    n = 1; len = 0;
    while (!b_ready && n < 200) begin
      if (!b_cs_n && !b_oe_n) len++;
      @(negedge clk); n++;
    end
    chk(len == 11, "R10", "100 ns bin read strobe cycles", len, 11);
    chk(n == 15, "R10", "100 ns bin read busy span", n, 15);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    do_write(19'h00000, 8'hA5);
    do_write(19'h7FFFF, 8'hFF);
    do_write(19'h2AAAA, 8'h00);
    do_read(19'h00000, 8'hA5);
    do_read(19'h7FFFF, 8'hFF);
    do_read(19'h2AAAA, 8'h00);
    do_write(19'h2AAAA, 8'h5A);   // directly after a read: R8 gap
    do_read(19'h2AAAA, 8'h5A);
    t_retention();
    t_bin100();
    repeat (4) @(negedge clk);
    report();
    $finish;
  end

endmodule